// File: doc/BRIEF.md
# MDIO Management Master

This block runs IEEE 802.3 Clause 22 management transactions toward an external PHY. A host sees four 32-bit registers. One holds the operation, the PHY address and the PHY register number. One holds the 16-bit value to write. One returns the 16-bit value captured by the last read. One holds an enable bit and a start/busy bit. The host programs the command and the write value, then writes the control register with both the start and the enable bits set. It then polls the busy bit until it reads zero, and after a read it fetches the result.

While a transaction runs, the block derives MDC from the system clock through a divider. It shifts the 64-bit frame out on MDIO and drives an output enable for the external tri-state pad. During a read, the block releases the line from the turnaround onward and samples the PHY's data on the rising MDC edges. MDC rests low whenever the block is idle.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Registers sit at byte offsets 0x0 (command: bit 10 read=1/write=0, bits [9:5] PHY address, bits [4:0] register number), 0x4 (write value, bits [15:0]), 0x8 (read result, bits [15:0], read-only) and 0xC (control: bit 0 start/busy, bit 3 enable). All other bits read as zero.
- R2: A control write with bits 0 and 3 both set, made while idle, sets busy in the next cycle and starts a frame. The enable bit keeps the written value.
- R3: A control write with bit 3 clear never starts a frame. Busy stays 0, MDC stays low and the output enable stays low.
- R4: The frame is 32 ones, then 01, then opcode 10 (read) or 01 (write), then the 5-bit PHY address, the 5-bit register number, turnaround 10 and 16 data bits, all MSB first. MDIO changes only after falling MDC edges, so each bit is stable at its rising edge.
- R5: In a read, MDIO is released from the turnaround (rising edge 47 of 64) onward. The line is sampled at rising edges 49 to 64, MSB first. The result appears in the read register when busy clears, and that register changes at no other time.
- R6: MDC is low when idle. Each MDC half period is MDC_HALF_DIV system cycles. A frame has 64 MDC periods, and busy stays high for exactly 128*MDC_HALF_DIV cycles.
- R7: Writes to the command and write-value registers while busy is set have no effect.
- R8: While busy is set, a control write can neither clear busy nor restart the frame. The enable bit still takes the written value.
- R9: The output enable is high for the whole of a write frame and is low whenever the block is idle.
- R10: After reset, all registers read zero, and MDC and the output enable are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset for reads and writes |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr, combinational |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO output to the pad |
| mdio_oe | output | 1 | MDIO pad output enable |

## Verification
A control write at a clock edge shows busy from the next cycle. The first MDC rise follows MDC_HALF_DIV cycles after that edge, and busy falls exactly 128*MDC_HALF_DIV cycles after it. The bench marks the cycle count just after the start write and polls busy on falling system-clock edges, so the measured window must equal that figure exactly. Frame bits and the output enable are captured one nanosecond after each MDC rise, when they must have been stable for half an MDC period. The PHY model changes mdio_i just after the previous rise, so each bit is held for a full MDC period before it is sampled. Register values are read on falling system-clock edges. The bench checks them one cycle after a write, or after busy has cleared.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_BIT     = 46;   // first turnaround position in the frame
  localparam int DATA_BIT   = 48;   // first data position in the frame

  localparam logic [3:0] OFF_CMD   = 4'h0;
  localparam logic [3:0] OFF_WVAL  = 4'h4;
  localparam logic [3:0] OFF_RVAL  = 4'h8;
  localparam logic [3:0] OFF_CTRL  = 4'hC;

  typedef struct packed {
    logic       rd;
    logic [4:0] phy;
    logic [4:0] regn;
  } mdio_cmd_t;

  function automatic logic [FRAME_BITS-1:0] make_frame(mdio_cmd_t c, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (c.rd ? 2'b10 : 2'b01), c.phy, c.regn, 2'b10, d};
  endfunction
endpackage

// File: rtl/mdio_mgmt_regs.sv
module mdio_mgmt_regs
  import mdio_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        done_i,
  input  logic [15:0] cap_i,
  output logic        start_o,
  output mdio_cmd_t   cmd_o,
  output logic [15:0] wval_o,
  output logic [15:0] rval_o,
  output logic        busy_o
);
  mdio_cmd_t   cmd_q, cmd_d;
  logic [15:0] wval_q, wval_d;
  logic [15:0] rval_q, rval_d;
  logic        en_q, en_d;
  logic        busy_q, busy_d;
  logic        wr_cmd, wr_wval, wr_ctrl, start;
  logic        unused_wbits;

  assign unused_wbits = ^bus_wdata[31:16];

  assign wr_cmd  = bus_we && (bus_addr == OFF_CMD)  && !busy_q;
  assign wr_wval = bus_we && (bus_addr == OFF_WVAL) && !busy_q;
  assign wr_ctrl = bus_we && (bus_addr == OFF_CTRL);
  assign start   = wr_ctrl && bus_wdata[0] && bus_wdata[3] && !busy_q;

  always_comb begin
    cmd_d  = cmd_q;
    wval_d = wval_q;
    rval_d = rval_q;
    en_d   = en_q;
    busy_d = busy_q;
    if (wr_cmd)  cmd_d  = mdio_cmd_t'(bus_wdata[10:0]);
    if (wr_wval) wval_d = bus_wdata[15:0];
    if (wr_ctrl) en_d   = bus_wdata[3];
    if (start)        busy_d = 1'b1;
    else if (done_i)  busy_d = 1'b0;
    if (done_i && cmd_q.rd) rval_d = cap_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      wval_q <= '0;
      rval_q <= '0;
      en_q   <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      wval_q <= wval_d;
      rval_q <= rval_d;
      en_q   <= en_d;
      busy_q <= busy_d;
    end
  end

  always_comb begin
    unique case (bus_addr)
      OFF_CMD:  bus_rdata = {21'd0, cmd_q};
      OFF_WVAL: bus_rdata = {16'd0, wval_q};
      OFF_RVAL: bus_rdata = {16'd0, rval_q};
      OFF_CTRL: bus_rdata = {28'd0, en_q, 2'b00, busy_q};
      default:  bus_rdata = 32'd0;
    endcase
  end

  assign start_o = start;
  assign cmd_o   = cmd_q;
  assign wval_o  = wval_q;
  assign rval_o  = rval_q;
  assign busy_o  = busy_q;
endmodule

// File: rtl/mdio_mgmt_clkgen.sv
module mdio_mgmt_clkgen #(
  parameter int HALF_DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          term;

  assign term = run_i && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run_i) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (term) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = term && !mdc_q;
  assign fall_o = term && mdc_q;
endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine
  import mdio_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  mdio_cmd_t   cmd_i,
  input  logic [15:0] wval_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        mdio_i,
  output logic        active_o,
  output logic        done_o,
  output logic [15:0] cap_o,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);

  logic                  active_q, active_d;
  logic                  rd_q, rd_d;
  logic [BW-1:0]         bit_q, bit_d;
  logic [FRAME_BITS-1:0] shf_q, shf_d;
  logic [15:0]           cap_q, cap_d;
  logic                  last;

  assign last   = (bit_q == LAST_BIT);
  assign done_o = active_q && fall_i && last;

  always_comb begin
    active_d = active_q;
    rd_d     = rd_q;
    bit_d    = bit_q;
    shf_d    = shf_q;
    cap_d    = cap_q;
    if (start_i) begin
      active_d = 1'b1;
      rd_d     = cmd_i.rd;
      bit_d    = '0;
      shf_d    = make_frame(cmd_i, wval_i);
      cap_d    = '0;
    end else if (active_q) begin
      if (rise_i && rd_q && (bit_q >= BW'(DATA_BIT)))
        cap_d = {cap_q[14:0], mdio_i};
      if (fall_i) begin
        if (last) begin
          active_d = 1'b0;
        end else begin
          bit_d = bit_q + 1'b1;
          shf_d = {shf_q[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      bit_q    <= '0;
      shf_q    <= '0;
      cap_q    <= '0;
    end else begin
      active_q <= active_d;
      rd_q     <= rd_d;
      bit_q    <= bit_d;
      shf_q    <= shf_d;
      cap_q    <= cap_d;
    end
  end

  assign active_o = active_q;
  assign cap_o    = cap_q;
  assign mdio_o   = shf_q[FRAME_BITS-1];
  assign mdio_oe  = active_q && (!rd_q || (bit_q < BW'(TA_BIT)));
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int MDC_HALF_DIV = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic [1:0]  rst_pipe;
  logic        rst_sync_n;
  logic        start, done, busy, active, rise, fall;
  mdio_cmd_t   cmd;
  logic [15:0] wreg, rreg, cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  mdio_mgmt_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done_i(done), .cap_i(cap),
    .start_o(start), .cmd_o(cmd), .wval_o(wreg), .rval_o(rreg), .busy_o(busy)
  );

  mdio_mgmt_clkgen #(.HALF_DIV(MDC_HALF_DIV)) u_clk (
    .clk(clk), .rst_n(rst_sync_n), .run_i(active),
    .mdc_o(mdc), .rise_o(rise), .fall_o(fall)
  );

  mdio_mgmt_engine u_eng (
    .clk(clk), .rst_n(rst_sync_n),
    .start_i(start), .cmd_i(cmd), .wval_i(wreg),
    .rise_i(rise), .fall_i(fall), .mdio_i(mdio_i),
    .active_o(active), .done_o(done), .cap_o(cap),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_we,
  input logic [3:0]  bus_addr,
  input logic        start_bit,
  input logic        en_bit,
  input logic        busy,
  input logic        mdc,
  input logic        mdio_oe,
  input logic [10:0] cmd,
  input logic [15:0] wreg,
  input logic [15:0] rreg
);
  // R2
  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 4'hC && start_bit && en_bit && !busy) |=> busy);
  // R3
  a_r3_disabled_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 4'hC && !en_bit && !busy) |=> !busy);
  // R6
  a_r6_mdc_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  // R9
  a_r9_oe_only_in_txn: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy);
  // R7
  a_r7_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cmd));
  a_r7_wval_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(wreg));
  // R5
  a_r5_rval_held_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(rreg));
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .start_bit(bus_wdata[0]), .en_bit(bus_wdata[3]),
  .busy(busy), .mdc(mdc), .mdio_oe(mdio_oe),
  .cmd(cmd), .wreg(wreg), .rreg(rreg)
);

// File: tb/mdio_mgmt_master_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_master_tb;
  localparam int DIV = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i_r = 1'b1;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  int rise_cnt = 0;
  logic [63:0] seen_bits, seen_oe;
  logic [15:0] phy_word = 16'd0;
  logic [15:0] exp_rval = 16'd0;

  mdio_mgmt_master #(.MDC_HALF_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_i(mdio_i_r), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // PHY model and line monitor
  always @(posedge mdc) begin
    #1;
    if (rise_cnt < 64) begin
      seen_bits[63-rise_cnt] = mdio_o;
      seen_oe[63-rise_cnt]   = mdio_oe;
    end
    rise_cnt = rise_cnt + 1;
    if (rise_cnt >= 48 && rise_cnt < 64) mdio_i_r = phy_word[63-rise_cnt];
    else mdio_i_r = 1'b1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] phy,
                                            input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, d};
  endfunction

  task automatic run_txn(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] wd, input logic [15:0] pw, input bit poke);
    logic [31:0] r;
    int t0, guard;
    logic [63:0] ef;
    bus_write(4'h0, {21'd0, rd, phy, rg});
    bus_write(4'h4, {16'd0, wd});
    phy_word = pw; rise_cnt = 0; mdio_i_r = 1'b1;
    seen_bits = '0; seen_oe = '0;
    bus_write(4'hC, 32'h9);
    t0 = cyc;
    bus_read(4'hC, r);
    chk("R2 busy set after start", 64'(r), 64'h9);
    if (poke) begin
      bus_write(4'h0, 32'h0000_07FF ^ {21'd0, rd, phy, rg});
      bus_write(4'h4, {16'd0, ~wd});
      bus_read(4'h0, r);
      chk("R7 command write ignored while busy", 64'(r), 64'({21'd0, rd, phy, rg}));
      bus_read(4'h4, r);
      chk("R7 write value ignored while busy", 64'(r), 64'({16'd0, wd}));
      bus_write(4'hC, 32'h8);
      bus_read(4'hC, r);
      chk("R8 host cannot clear busy", 64'(r), 64'h9);
      bus_write(4'hC, 32'h9);
    end
    guard = 0;
    do begin
      bus_read(4'hC, r);
      guard++;
    end while (r[0] && guard < 20000);
    chk("R6 busy duration", 64'(cyc - t0), 64'(128 * DIV));
    chk("R6 MDC periods per frame", 64'(rise_cnt), 64'd64);
    chk("R6 MDC low when idle", {63'd0, mdc}, 64'd0);
    chk("R9 output enable off when idle", {63'd0, mdio_oe}, 64'd0);
    ef = exp_frame(rd, phy, rg, wd);
    if (rd) begin
      chk("R4 read frame header", {18'd0, seen_bits[63:18]}, {18'd0, ef[63:18]});
      chk("R5 release from turnaround", seen_oe, {{46{1'b1}}, 18'd0});
      exp_rval = pw;
    end else begin
      chk("R4 write frame", seen_bits, ef);
      chk("R9 output enable for whole write", seen_oe, {64{1'b1}});
    end
    bus_read(4'h8, r);
    chk("R5 read register", 64'(r), 64'({16'd0, exp_rval}));
    bus_read(4'hC, r);
    chk("R2 enable retained", 64'(r), 64'h8);
  endtask

  initial begin
    #(4 * 190000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int unused_seed;
    unused_seed = $urandom(32'd4242);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    for (int a = 0; a < 4; a++) begin
      bus_read(4'(a * 4), r);
      chk("R10 register reset value", 64'(r), 64'd0);
    end
    chk("R10 MDC low", {63'd0, mdc}, 64'd0);
    chk("R10 output enable low", {63'd0, mdio_oe}, 64'd0);

    // R1 field widths and read-only result
    bus_write(4'h0, 32'hFFFF_FFFF);
    bus_read(4'h0, r); chk("R1 command fields", 64'(r), 64'h7FF);
    bus_write(4'h4, 32'hFFFF_FFFF);
    bus_read(4'h4, r); chk("R1 write value field", 64'(r), 64'hFFFF);
    bus_write(4'h8, 32'hFFFF_FFFF);
    bus_read(4'h8, r); chk("R1 read register is read-only", 64'(r), 64'd0);
    bus_write(4'hC, 32'hFFFF_FFF6);
    bus_read(4'hC, r); chk("R1 control unused bits", 64'(r), 64'd0);

    // R3 start without enable
    rise_cnt = 0;
    bus_write(4'hC, 32'h1);
    repeat (20) @(negedge clk);
    bus_read(4'hC, r); chk("R3 start ignored without enable", 64'(r), 64'd0);
    chk("R3 no MDC edges", 64'(rise_cnt), 64'd0);
    chk("R3 MDC low", {63'd0, mdc}, 64'd0);
    chk("R3 output enable low", {63'd0, mdio_oe}, 64'd0);
    bus_write(4'hC, 32'h8);
    bus_read(4'hC, r); chk("R1 enable bit only", 64'(r), 64'h8);

    // directed corners
    run_txn(1'b0, 5'd0,  5'd0,  16'h0000, 16'h0000, 1'b0);
    run_txn(1'b1, 5'd31, 5'd31, 16'h1234, 16'hFFFF, 1'b0);
    run_txn(1'b1, 5'd1,  5'd2,  16'h0000, 16'hA55A, 1'b1);
    run_txn(1'b0, 5'd17, 5'd9,  16'hC3E1, 16'h0000, 1'b1);
    run_txn(1'b1, 5'd5,  5'd6,  16'h0000, 16'h0000, 1'b0);

    // random mix
    for (int i = 0; i < 20; i++) begin
      run_txn(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom),
              1'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule